// File: doc/BRIEF.md
# Shared-Bus Register Transfer Datapath

This block moves words between four general registers and a small memory over one shared bus. A two-bit source code, gated by a bus enable, decides which general register drives the bus. Every destination (each general register, the address register and the data register) has its own load strobe. Each one captures the bus on the next rising clock edge. The memory is word addressed by the address register. A read copies the addressed word into the data register. A write stores the current bus word at the addressed location.

All control inputs come straight from the surrounding logic; there is no sequencing inside. The four general registers start at zero, and the bus only carries their values, so a direct seed port is provided to give each register a starting value. Reset is synchronous and active low. It clears every register but leaves the memory contents as they were.

Top module: `regbus_xfer`

## Requirements
- R1: With `bus_en` high, `bus_out` equals register A, B, C or D for `bus_sel` codes 0, 1, 2 and 3 respectively, combinationally in the same cycle.
- R2: With `bus_en` low, `bus_out` is all zeros whatever `bus_sel` holds.
- R3: When `bus_en` is high and bit i of `gpr_load` is set (bit 0 = A … bit 3 = D), register i holds the bus word after the next rising edge.
- R4: A general register that is not loaded in a cycle keeps its value across the edge. This includes a register whose load bit is set while `bus_en` is low.
- R5: The address register takes the low `$clog2(DEPTH)` bus bits at the edge when `addr_load` and `bus_en` are both high; otherwise it holds.
- R6: The data register takes the bus word at the edge when `data_load` and `bus_en` are high and `mem_rd` is low; otherwise, without `mem_rd`, it holds.
- R7: When `mem_rd` is high, the data register receives the memory word addressed by the address register at that edge. This happens whatever `bus_en` holds, and it takes priority over `data_load`.
- R8: When `mem_wr` and `bus_en` are high, the bus word is stored at the addressed memory word. When `bus_en` is low, `mem_wr` leaves the memory unchanged.
- R9: Every memory access at an edge uses the address register value from before that edge. A read and a write to the same word at the same edge returns the old word.
- R10: While `rst_n` is low at a rising edge, all four general registers, the address register and the data register become zero. Memory contents are retained across reset.
- R11: When `seed_en` is high, the register chosen by `seed_sel` (same code as R1) takes `seed_word` at the edge. This takes priority over a bus load of that register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_en | input | 1 | Bus enable; low means no source drives and no bus load occurs |
| bus_sel | input | 2 | Bus source code: 0=A, 1=B, 2=C, 3=D |
| gpr_load | input | 4 | Per-register bus load strobes, bit 0=A to bit 3=D |
| addr_load | input | 1 | Load address register from bus |
| data_load | input | 1 | Load data register from bus |
| mem_rd | input | 1 | Copy addressed memory word into data register |
| mem_wr | input | 1 | Store bus word at addressed memory word |
| seed_en | input | 1 | Direct write of `seed_word` into one general register |
| seed_sel | input | 2 | Register chosen for the seed write |
| seed_word | input | W | Value for the seed write |
| bus_out | output | W | Current bus word |
| gpr_a | output | W | Register A |
| gpr_b | output | W | Register B |
| gpr_c | output | W | Register C |
| gpr_d | output | W | Register D |
| addr_q | output | $clog2(DEPTH) | Address register |
| data_q | output | W | Data register |

## Verification
The bus word is combinational. The bench checks it one time step after driving the controls, before the clock rises. Every register and memory effect is due exactly one rising edge later. The bench predicts it from the state held before that edge and compares it one time step after the edge. Controls are always changed on the falling edge. A memory write is only seen through a later read into the data register, which is again one edge behind its control.

// File: rtl/regbus_pkg.sv
// Shared constants for the register bus datapath.
// Assumes exactly four bus sources addressed by a binary code.
package regbus_pkg;
    localparam int NSRC  = 4;
    localparam int SEL_W = $clog2(NSRC);
endpackage

// File: rtl/regbus_src_dec.sv
// Source decoder: turns a binary source code plus enable into a
// one-hot (or all-zero) drive vector. Assumes N is a power of two.
module regbus_src_dec #(
    parameter int N = 4,
    localparam int SW = $clog2(N)
) (
    input  logic [SW-1:0] sel,
    input  logic          en,
    output logic [N-1:0]  drive
);
    for (genvar i = 0; i < N; i++) begin : g_dec
        // one decoder output per source, gated by the enable
        assign drive[i] = en && (sel == SW'(i));
    end
endmodule

// File: rtl/regbus_mux.sv
// Bus multiplexer: each bus bit is an AND-OR of bit b of every source
// with its drive line. Assumes drive is one-hot or zero; zero yields 0.
module regbus_mux #(
    parameter int W = 8,
    parameter int N = 4
) (
    input  logic [N*W-1:0] src,
    input  logic [N-1:0]   drive,
    output logic [W-1:0]   bus
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        // per-bit N-to-1 selection
        always_comb begin
            bus[b] = 1'b0;
            for (int s = 0; s < N; s++) begin
                bus[b] = bus[b] | (src[s*W+b] & drive[s]);
            end
        end
    end
endmodule

// File: rtl/regbus_mem.sv
// Word-addressed storage: synchronous write, combinational read.
// Assumes no reset; contents persist until overwritten.
module regbus_mem #(
    parameter int W     = 8,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] cells [DEPTH];

    // store the write word at the edge
    always_ff @(posedge clk) begin
        if (we) cells[addr] <= wdata;
    end

    assign rdata = cells[addr];
endmodule

// File: rtl/regbus_xfer.sv
// Shared-bus transfer datapath: four general registers drive one bus
// through a decoder and mux; registers, address and data registers load
// from the bus; memory is read into and written from the bus via the
// address register. Assumes W >= $clog2(DEPTH). Reset is synchronous,
// active low, and leaves the memory untouched.
module regbus_xfer
    import regbus_pkg::*;
#(
    parameter int W     = 8,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_en,
    input  logic [SEL_W-1:0] bus_sel,
    input  logic [NSRC-1:0]  gpr_load,
    input  logic             addr_load,
    input  logic             data_load,
    input  logic             mem_rd,
    input  logic             mem_wr,
    input  logic             seed_en,
    input  logic [SEL_W-1:0] seed_sel,
    input  logic [W-1:0]     seed_word,
    output logic [W-1:0]     bus_out,
    output logic [W-1:0]     gpr_a,
    output logic [W-1:0]     gpr_b,
    output logic [W-1:0]     gpr_c,
    output logic [W-1:0]     gpr_d,
    output logic [AW-1:0]    addr_q,
    output logic [W-1:0]     data_q
);
    logic [NSRC-1:0][W-1:0] gpr_q;
    logic [NSRC-1:0]        drive;
    logic [W-1:0]           bus;
    logic [W-1:0]           mem_word;
    logic [NSRC-1:0]        seed_hit;

    regbus_src_dec #(.N(NSRC)) u_dec (
        .sel   (bus_sel),
        .en    (bus_en),
        .drive (drive)
    );

    regbus_mux #(.W(W), .N(NSRC)) u_mux (
        .src   (gpr_q),
        .drive (drive),
        .bus   (bus)
    );

    regbus_mem #(.W(W), .DEPTH(DEPTH)) u_mem (
        .clk   (clk),
        .we    (mem_wr && bus_en),
        .addr  (addr_q),
        .wdata (bus),
        .rdata (mem_word)
    );

    for (genvar i = 0; i < NSRC; i++) begin : g_gpr
        assign seed_hit[i] = seed_en && (seed_sel == SEL_W'(i));

        // general register: seed beats bus load, bus load needs enable
        always_ff @(posedge clk) begin
            if (!rst_n)                         gpr_q[i] <= '0;
            else if (seed_hit[i])               gpr_q[i] <= seed_word;
            else if (bus_en && gpr_load[i])     gpr_q[i] <= bus;
        end
    end

    // address register: low bus bits when enabled
    always_ff @(posedge clk) begin
        if (!rst_n)                      addr_q <= '0;
        else if (bus_en && addr_load)    addr_q <= bus[AW-1:0];
    end

    // data register: memory read beats bus load
    always_ff @(posedge clk) begin
        if (!rst_n)                      data_q <= '0;
        else if (mem_rd)                 data_q <= mem_word;
        else if (bus_en && data_load)    data_q <= bus;
    end

    assign bus_out = bus;
    assign gpr_a   = gpr_q[0];
    assign gpr_b   = gpr_q[1];
    assign gpr_c   = gpr_q[2];
    assign gpr_d   = gpr_q[3];
endmodule

// File: rtl/regbus_xfer_chk.sv
// Property checker for regbus_xfer, attached by bind. Observes ports
// plus the memory read word; drives nothing.
module regbus_xfer_chk #(
    parameter int W  = 8,
    parameter int AW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_en,
    input logic [1:0]    bus_sel,
    input logic [3:0]    gpr_load,
    input logic          addr_load,
    input logic          data_load,
    input logic          mem_rd,
    input logic          seed_en,
    input logic [1:0]    seed_sel,
    input logic [W-1:0]  seed_word,
    input logic [W-1:0]  bus_out,
    input logic [W-1:0]  gpr_a,
    input logic [W-1:0]  gpr_b,
    input logic [W-1:0]  gpr_c,
    input logic [W-1:0]  gpr_d,
    input logic [AW-1:0] addr_q,
    input logic [W-1:0]  data_q,
    input logic [W-1:0]  mem_word
);
    logic [W-1:0] g [4];
    assign g[0] = gpr_a;
    assign g[1] = gpr_b;
    assign g[2] = gpr_c;
    assign g[3] = gpr_d;

    assert_bus_pick_R1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_en |-> bus_out == g[bus_sel]);

    assert_bus_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_en |-> bus_out == '0);

    for (genvar i = 0; i < 4; i++) begin : g_reg
        assert_gpr_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_en && gpr_load[i] && !(seed_en && seed_sel == 2'(i)))
            |=> g[i] == $past(bus_out));

        assert_gpr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (!(bus_en && gpr_load[i]) && !(seed_en && seed_sel == 2'(i)))
            |=> $stable(g[i]));

        assert_gpr_seed_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (seed_en && seed_sel == 2'(i)) |=> g[i] == $past(seed_word));
    end

    assert_addr_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && addr_load) |=> addr_q == $past(bus_out[AW-1:0]));

    assert_data_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && data_load && !mem_rd) |=> data_q == $past(bus_out));

    assert_data_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> data_q == $past(mem_word));

    assert_reset_clear_R10: assert property (@(posedge clk)
        !rst_n |=> (gpr_a == '0 && gpr_b == '0 && gpr_c == '0 &&
                    gpr_d == '0 && addr_q == '0 && data_q == '0));
endmodule

bind regbus_xfer regbus_xfer_chk #(.W(W), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_en    (bus_en),
    .bus_sel   (bus_sel),
    .gpr_load  (gpr_load),
    .addr_load (addr_load),
    .data_load (data_load),
    .mem_rd    (mem_rd),
    .seed_en   (seed_en),
    .seed_sel  (seed_sel),
    .seed_word (seed_word),
    .bus_out   (bus_out),
    .gpr_a     (gpr_a),
    .gpr_b     (gpr_b),
    .gpr_c     (gpr_c),
    .gpr_d     (gpr_d),
    .addr_q    (addr_q),
    .data_q    (data_q),
    .mem_word  (mem_word)
);

// File: tb/regbus_xfer_tb.sv
// Self-checking bench: sweeps bus codes, enables and load patterns,
// fills and reads back the memory, and runs a random phase against a
// bench-side model of the transfer rules.
module regbus_xfer_tb;
    localparam int W     = 8;
    localparam int DEPTH = 16;
    localparam int AW    = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_en = 1'b0;
    logic [1:0]    bus_sel = '0;
    logic [3:0]    gpr_load = '0;
    logic          addr_load = 1'b0;
    logic          data_load = 1'b0;
    logic          mem_rd = 1'b0;
    logic          mem_wr = 1'b0;
    logic          seed_en = 1'b0;
    logic [1:0]    seed_sel = '0;
    logic [W-1:0]  seed_word = '0;
    logic [W-1:0]  bus_out, gpr_a, gpr_b, gpr_c, gpr_d, data_q;
    logic [AW-1:0] addr_q;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [W-1:0]  m_r [4];
    logic [AW-1:0] m_ar;
    logic [W-1:0]  m_dr;
    bit            m_drk;
    logic [W-1:0]  m_mem [DEPTH];
    bit            m_memk [DEPTH];
    string         ph = "";

    always #5 clk = ~clk;

    regbus_xfer #(.W(W), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_sel(bus_sel),
        .gpr_load(gpr_load), .addr_load(addr_load), .data_load(data_load),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .seed_en(seed_en),
        .seed_sel(seed_sel), .seed_word(seed_word), .bus_out(bus_out),
        .gpr_a(gpr_a), .gpr_b(gpr_b), .gpr_c(gpr_c), .gpr_d(gpr_d),
        .addr_q(addr_q), .data_q(data_q)
    );

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, ph, act, exp);
        end
    endtask

    function automatic logic [W-1:0] gpr_port(input int i);
        case (i)
            0: return gpr_a;
            1: return gpr_b;
            2: return gpr_c;
            default: return gpr_d;
        endcase
    endfunction

    // One cycle: drive on the falling edge, check bus, then state after the edge.
    task automatic step(input bit en, input logic [1:0] sel, input logic [3:0] ld,
                        input bit la, input bit ldd, input bit rd, input bit wr,
                        input bit sen, input logic [1:0] ssel, input logic [W-1:0] sw);
        logic [W-1:0] eb;
        logic [W-1:0] nr [4];
        logic [AW-1:0] nar;
        logic [W-1:0] ndr;
        bit ndrk;
        @(negedge clk);
        bus_en = en; bus_sel = sel; gpr_load = ld; addr_load = la;
        data_load = ldd; mem_rd = rd; mem_wr = wr;
        seed_en = sen; seed_sel = ssel; seed_word = sw;
        #1;
        eb = en ? m_r[sel] : '0;
        chk(en ? "R1" : "R2", bus_out, eb);
        for (int i = 0; i < 4; i++) begin
            if (sen && ssel == 2'(i))   nr[i] = sw;
            else if (en && ld[i])       nr[i] = eb;
            else                        nr[i] = m_r[i];
        end
        nar  = (en && la) ? eb[AW-1:0] : m_ar;
        ndr  = m_dr; ndrk = m_drk;
        if (rd) begin ndr = m_mem[m_ar]; ndrk = m_memk[m_ar]; end
        else if (en && ldd) begin ndr = eb; ndrk = 1; end
        if (en && wr) begin m_mem[m_ar] = eb; m_memk[m_ar] = 1; end
        @(posedge clk);
        #1;
        for (int i = 0; i < 4; i++) m_r[i] = nr[i];
        m_ar = nar; m_dr = ndr; m_drk = ndrk;
        for (int i = 0; i < 4; i++)
            chk((sen && ssel == 2'(i)) ? "R11" : ((en && ld[i]) ? "R3" : "R4"),
                gpr_port(i), m_r[i]);
        chk("R5", W'(addr_q), W'(m_ar));
        if (m_drk) chk(rd ? "R7" : "R6", data_q, m_dr);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; bus_en = 1; gpr_load = '1; addr_load = 1; data_load = 1;
        mem_rd = 1; mem_wr = 0; seed_en = 1; seed_word = '1;
        @(posedge clk);
        #1;
        for (int i = 0; i < 4; i++) begin
            m_r[i] = '0;
            chk("R10", gpr_port(i), '0);
        end
        m_ar = '0; m_dr = '0; m_drk = 1;
        chk("R10", W'(addr_q), '0);
        chk("R10", data_q, '0);
        @(negedge clk);
        rst_n = 1; bus_en = 0; gpr_load = '0; addr_load = 0; data_load = 0;
        mem_rd = 0; seed_en = 0;
    endtask

    // write word v at address a, using register A for the address and B for data
    task automatic mem_put(input logic [AW-1:0] a, input logic [W-1:0] v);
        step(0, 0, 0, 0, 0, 0, 0, 1, 0, W'(a));
        step(1, 0, 0, 1, 0, 0, 0, 1, 1, v);
        step(1, 1, 0, 0, 0, 0, 1, 0, 0, '0);
    endtask

    task automatic mem_get(input logic [AW-1:0] a);
        step(0, 0, 0, 0, 0, 0, 0, 1, 0, W'(a));
        step(1, 0, 0, 1, 0, 0, 0, 0, 0, '0);
        step(0, 0, 0, 0, 0, 1, 0, 0, 0, '0);
    endtask

    initial begin
        for (int a = 0; a < DEPTH; a++) m_memk[a] = 0;
        m_drk = 0;
        // reset state
        ph = "reset";
        @(posedge clk); @(posedge clk);
        do_reset();

        // seed distinct values
        ph = "seed";
        step(0, 0, 0, 0, 0, 0, 0, 1, 0, 8'h3C);
        step(0, 0, 0, 0, 0, 0, 0, 1, 1, 8'hA5);
        step(0, 0, 0, 0, 0, 0, 0, 1, 2, 8'h0F);
        step(0, 0, 0, 0, 0, 0, 0, 1, 3, 8'hF0);

        // sweep enable, source code and load pattern
        ph = "sweep";
        for (int en = 0; en < 2; en++)
            for (int s = 0; s < 4; s++)
                for (int ld = 0; ld < 16; ld++)
                    step(en[0], 2'(s), 4'(ld), ld[0], ld[1], 0, 0,
                         ld[2], 2'(ld + s + 1), W'($urandom));

        // R8 write fill and read back
        ph = "R8 fill";
        for (int a = 0; a < DEPTH; a++) mem_put(AW'(a), W'(a * 37 + 11));
        ph = "R8 readback";
        for (int a = DEPTH - 1; a >= 0; a--) mem_get(AW'(a));

        // R8 write with bus disabled is ignored
        ph = "R8 disabled write";
        step(0, 0, 0, 0, 0, 0, 0, 1, 0, 8'd5);
        step(1, 0, 0, 1, 0, 0, 0, 1, 1, 8'hEE);
        step(0, 1, 0, 0, 0, 0, 1, 0, 0, '0);
        step(0, 0, 0, 0, 0, 1, 0, 0, 0, '0);

        // R7 read beats data load
        ph = "R7 priority";
        step(1, 1, 0, 0, 1, 1, 0, 0, 0, '0);

        // R9 same-edge: write and read together, address reloaded too
        ph = "R9 same-edge";
        step(1, 2, 0, 1, 0, 1, 1, 0, 0, '0);
        mem_get(AW'(5));
        mem_get(m_ar);

        // R10 retained memory after reset
        ph = "R10 retained";
        do_reset();
        for (int a = 0; a < DEPTH; a++) mem_get(AW'(a));

        // random phase
        ph = "random";
        for (int n = 0; n < 1500; n++) begin
            logic [31:0] r;
            r = $urandom;
            step(r[0] | r[1], r[3:2], r[7:4], r[8], r[9], r[10] & r[11],
                 r[12] & r[13], r[14] & r[15], r[17:16], r[31:24]);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule